// File: doc/BRIEF.md
# Oversampled Serial Receiver with Selectable Parity

This block recovers 8-bit characters from an asynchronous serial line. An external rate generator supplies a tick at sixteen times the bit rate. On each tick the receiver advances through the frame: a start bit, the data bits least significant first, an optional parity bit, then a stop bit. Each bit is sampled once, near the middle of its bit time. When the stop bit is sampled the byte is committed to the data output, a ready flag is raised, and the parity bit that was received is compared with the value the selected rule predicts.

A 3-bit mode input selects even, odd, fixed-one, fixed-zero or no parity. Parity mismatches and overruns are recorded in sticky flags that stay set until software pulses a status-clear strobe. The ready flag drops when software pulses a read strobe. A small combinational helper computes the parity bit that a transmitter would append to a given byte under the same mode, so the transmit side and the receive side follow one rule.

Top module: `uart_par_rx`

## Requirements
- R1: A frame is a low start bit, then data bits D0 to D7 with D0 first, then a parity bit when the mode uses one, then a high stop bit. The received byte appears on rx_data once the stop bit has been sampled.
- R2: Mode 3'b000 (even): the expected parity bit is 1 when the data holds an odd number of ones and 0 otherwise. A mismatch sets par_err.
- R3: Mode 3'b001 (odd): the expected parity bit is 1 when the data holds an even number of ones and 0 otherwise. A mismatch sets par_err.
- R4: Mode 3'b011 (mark): the expected parity bit is always 1. A sampled 0 sets par_err.
- R5: Mode 3'b010 (space): the expected parity bit is always 0. A sampled 1 sets par_err.
- R6: Mode 3'b100 and the unused codes 3'b101 to 3'b111 mean no parity. The stop bit follows D7 directly and par_err is never set by such a frame.
- R7: par_err changes only when a character completes. Once set it stays set through later frames, good or bad, until it is cleared.
- R8: A one-cycle rst_status pulse clears par_err and overrun. If rst_status coincides with the completion of a frame with a parity error, par_err ends up set.
- R9: After reset rx_ready, par_err, overrun and rx_data are 0. rx_ready rises when a character completes and falls after a rd_strobe pulse.
- R10: A character that completes while rx_ready is still set replaces rx_data and sets overrun.
- R11: A bit is sampled on the eighth tick into its bit time. A start bit that is high again by then is dropped as a glitch: no character is delivered.
- R12: The transmit helper gives tx_par_bit per R2 to R5 for tx_byte under par_mode, and tx_par_en is 0 in the no-parity modes. For 0x41 the bit is 1 in odd, 0 in even, 1 in mark and 0 in space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_mode | input | 3 | Parity rule select |
| rd_strobe | input | 1 | Read pulse, clears rx_ready |
| rst_status | input | 1 | Status-clear pulse for par_err and overrun |
| tx_byte | input | 8 | Byte for the transmit parity helper |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | A received byte is waiting to be read |
| par_err | output | 1 | Sticky parity error |
| overrun | output | 1 | Sticky overrun |
| tx_par_bit | output | 1 | Parity bit for tx_byte |
| tx_par_en | output | 1 | The mode uses a parity bit |

## Verification
The hardest situation to reach is a status-clear strobe that falls in the same cycle as the commit of a frame that carries a bad parity bit. From the ports the commit cycle is known only to within one tick, so the stimulus raises rst_status at the start of the stop bit, when par_err is already set from an earlier frame, and keeps it high until rx_ready is seen rising. That window covers the commit cycle, so the flag first clears and then has to be set again by the new error. The glitch case is driven as a start pulse only two ticks long, followed by a check that no byte arrives.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam logic [2:0] PM_EVEN  = 3'b000;
   localparam logic [2:0] PM_ODD   = 3'b001;
   localparam logic [2:0] PM_SPACE = 3'b010;
   localparam logic [2:0] PM_MARK  = 3'b011;
   localparam logic [2:0] PM_NONE  = 3'b100;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
   } rx_state_e;

   // Only codes with bit 2 clear carry a parity bit
   function automatic logic mode_has_parity(input logic [2:0] m);
      return (m[2] == 1'b0);
   endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 1'b1;
            else        ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d};
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rx_pargen.sv
module uart_rx_pargen
   import uart_rx_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] data,
   input  logic [2:0]       mode,
   output logic             par_bit,
   output logic             par_en
);
   logic ones_odd;
   assign ones_odd = ^data;

   always_comb begin
      par_en = mode_has_parity(mode);
      case (mode)
         PM_EVEN:  par_bit = ones_odd;
         PM_ODD:   par_bit = ~ones_odd;
         PM_MARK:  par_bit = 1'b1;
         PM_SPACE: par_bit = 1'b0;
         default:  par_bit = 1'b0;
      endcase
   end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OVS       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd_s,
   input  logic                 tick,
   input  logic                 par_en,
   output logic [DATA_BITS-1:0] shift_q,
   output logic                 par_smp,
   output logic                 par_used,
   output logic                 done
);
   localparam int CW   = $clog2(OVS);
   localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam int HALF = OVS / 2;

   rx_state_e      state;
   logic [CW-1:0]  cnt;
   logic [IW-1:0]  idx;
   logic           mid_start;
   logic           bit_end;

   assign mid_start = (cnt == CW'(HALF - 1));
   assign bit_end   = (cnt == CW'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         idx      <= '0;
         shift_q  <= '0;
         par_smp  <= 1'b0;
         par_used <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  if (!rxd_s) begin
                     cnt   <= '0;
                     state <= ST_START;
                  end
               end
               ST_START: begin
                  if (mid_start) begin
                     cnt <= '0;
                     idx <= '0;
                     par_used <= 1'b0;
                     state <= rxd_s ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (bit_end) begin
                     cnt     <= '0;
                     shift_q <= {rxd_s, shift_q[DATA_BITS-1:1]};
                     if (idx == IW'(DATA_BITS - 1)) begin
                        par_used <= par_en;
                        state    <= par_en ? ST_PAR : ST_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (bit_end) begin
                     cnt     <= '0;
                     par_smp <= rxd_s;
                     state   <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (bit_end) begin
                     cnt   <= '0;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done,
   input  logic [DATA_BITS-1:0] data_in,
   input  logic                 par_bad,
   input  logic                 rd_strobe,
   input  logic                 rst_status,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 par_err,
   output logic                 overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_ready <= 1'b0;
         par_err  <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         if (done)           rx_data <= data_in;

         if (done)           rx_ready <= 1'b1;
         else if (rd_strobe) rx_ready <= 1'b0;

         if (done && par_bad) par_err <= 1'b1;
         else if (rst_status) par_err <= 1'b0;

         if (done && rx_ready && !rd_strobe) overrun <= 1'b1;
         else if (rst_status)                overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx #(
   parameter int DATA_BITS   = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd,
   input  logic                 baud_tick,
   input  logic [2:0]           par_mode,
   input  logic                 rd_strobe,
   input  logic                 rst_status,
   input  logic [DATA_BITS-1:0] tx_byte,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 par_err,
   output logic                 overrun,
   output logic                 tx_par_bit,
   output logic                 tx_par_en
);
   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("DATA_BITS must lie between 5 and 9");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic                 rxd_s;
   logic [DATA_BITS-1:0] shift_q;
   logic                 par_smp;
   logic                 par_used;
   logic                 frame_done;
   logic                 exp_bit;
   logic                 rx_par_en;
   logic                 par_bad;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst_n (rst_n),
      .d (rxd),
      .q (rxd_s)
   );

   uart_rx_core #(.DATA_BITS(DATA_BITS), .OVS(OVS)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxd_s    (rxd_s),
      .tick     (baud_tick),
      .par_en   (rx_par_en),
      .shift_q  (shift_q),
      .par_smp  (par_smp),
      .par_used (par_used),
      .done     (frame_done)
   );

   uart_rx_pargen #(.WIDTH(DATA_BITS)) rx_chk_i (
      .data    (shift_q),
      .mode    (par_mode),
      .par_bit (exp_bit),
      .par_en  (rx_par_en)
   );

   assign par_bad = par_used && (par_smp != exp_bit);

   uart_rx_status #(.DATA_BITS(DATA_BITS)) status_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (frame_done),
      .data_in    (shift_q),
      .par_bad    (par_bad),
      .rd_strobe  (rd_strobe),
      .rst_status (rst_status),
      .rx_data    (rx_data),
      .rx_ready   (rx_ready),
      .par_err    (par_err),
      .overrun    (overrun)
   );

   uart_rx_pargen #(.WIDTH(DATA_BITS)) tx_gen_i (
      .data    (tx_byte),
      .mode    (par_mode),
      .par_bit (tx_par_bit),
      .par_en  (tx_par_en)
   );
endmodule

// File: rtl/uart_par_rx_chk.sv
module uart_par_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rst_status,
   input logic       rd_strobe,
   input logic [2:0] par_mode,
   input logic       frame_done,
   input logic       par_bad,
   input logic       par_used,
   input logic       rx_ready,
   input logic       par_err,
   input logic       overrun,
   input logic       tx_par_bit,
   input logic       tx_par_en
);
   p_err_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> $past(frame_done));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !rst_status) |=> par_err);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_status && !frame_done) |=> (!par_err && !overrun));

   p_new_err_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_status && frame_done && par_bad) |=> par_err);

   p_ready_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> rx_ready);

   p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && rx_ready && !rd_strobe) |=> overrun);

   p_none_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !par_used && !rst_status) |=> (par_err == $past(par_err)));

   p_tx_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode == 3'b011) |-> (tx_par_bit && tx_par_en));

   p_tx_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode == 3'b010) |-> (!tx_par_bit && tx_par_en));

   p_tx_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
      par_mode[2] |-> !tx_par_en);
endmodule

bind uart_par_rx uart_par_rx_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_status (rst_status),
   .rd_strobe  (rd_strobe),
   .par_mode   (par_mode),
   .frame_done (frame_done),
   .par_bad    (par_bad),
   .par_used   (par_used),
   .rx_ready   (rx_ready),
   .par_err    (par_err),
   .overrun    (overrun),
   .tx_par_bit (tx_par_bit),
   .tx_par_en  (tx_par_en)
);

// File: tb/uart_par_rx_tb_top.sv
module uart_par_rx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TDIV       = 4;
   localparam int OVS        = 16;
   localparam int BITCLK     = TDIV * OVS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       baud_tick = 1'b0;
   logic [2:0] par_mode = 3'b000;
   logic       rd_strobe = 1'b0;
   logic       rst_status = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic [7:0] rx_data;
   logic       rx_ready;
   logic       par_err;
   logic       overrun;
   logic       tx_par_bit;
   logic       tx_par_en;

   int n_chk = 0;
   int n_fail = 0;
   logic model_err = 1'b0;
   logic [8:0] exp_q[$];   // {err, data}

   uart_par_rx dut_i (
      .clk (clk), .rst_n (rst_n), .rxd (rxd), .baud_tick (baud_tick),
      .par_mode (par_mode), .rd_strobe (rd_strobe), .rst_status (rst_status),
      .tx_byte (tx_byte), .rx_data (rx_data), .rx_ready (rx_ready),
      .par_err (par_err), .overrun (overrun),
      .tx_par_bit (tx_par_bit), .tx_par_en (tx_par_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      forever begin
         repeat (TDIV-1) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic uses_par(input logic [2:0] m);
      return (m == 3'b000 || m == 3'b001 || m == 3'b010 || m == 3'b011);
   endfunction

   function automatic logic ref_bit(input logic [2:0] m, input logic [7:0] d);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += d[i];
      case (m)
         3'b000:  return (ones % 2) == 1;
         3'b001:  return (ones % 2) == 0;
         3'b011:  return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Driver: serialises a frame and records the expected result
   task automatic send_frame(input logic [7:0] d, input bit corrupt,
                             input bit push, input bit hold_rst);
      logic pb;
      logic bad;
      pb  = ref_bit(par_mode, d) ^ corrupt;
      bad = uses_par(par_mode) && corrupt;
      if (hold_rst) model_err = bad;
      else          model_err = model_err | bad;
      if (push) exp_q.push_back({model_err, d});
      rxd = 1'b0;
      repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i];
         repeat (BITCLK) @(negedge clk);
      end
      if (uses_par(par_mode)) begin
         rxd = pb;
         repeat (BITCLK) @(negedge clk);
      end
      rxd = 1'b1;
      if (hold_rst) rst_status = 1'b1;
      for (int k = 0; k < BITCLK; k++) begin
         @(negedge clk);
         if (hold_rst && rx_ready) rst_status = 1'b0;
      end
      rst_status = 1'b0;
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
      check(rx_ready == 1'b0, "R9", "rx_ready after read", rx_ready, 0);
   endtask

   task automatic do_clear();
      rst_status = 1'b1;
      @(negedge clk);
      rst_status = 1'b0;
      model_err = 1'b0;
      @(negedge clk);
      check(par_err == 1'b0, "R8", "par_err after clear", par_err, 0);
      check(overrun == 1'b0, "R8", "overrun after clear", overrun, 0);
   endtask

   task automatic tx_check(input logic [2:0] m, input logic [7:0] d,
                           input logic eb, input logic ee, input string req);
      par_mode = m;
      tx_byte  = d;
      @(negedge clk);
      check(tx_par_bit == eb, req, "tx_par_bit", tx_par_bit, eb);
      check(tx_par_en == ee, req, "tx_par_en", tx_par_en, ee);
   endtask

   // Monitor: compares each delivered character with the scoreboard
   initial begin
      logic prev_rdy;
      logic [8:0] e;
      prev_rdy = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && rx_ready && !prev_rdy) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected character", rx_data, 0);
            end else begin
               e = exp_q.pop_front();
               check(rx_data == e[7:0], "R1", "rx_data", rx_data, e[7:0]);
               check(par_err == e[8], "R7", "par_err at delivery", par_err, e[8]);
            end
         end
         prev_rdy = rx_ready;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(rx_ready == 1'b0, "R9", "rx_ready at reset", rx_ready, 0);
      check(par_err == 1'b0, "R9", "par_err at reset", par_err, 0);
      check(overrun == 1'b0, "R9", "overrun at reset", overrun, 0);
      check(rx_data == 8'h00, "R9", "rx_data at reset", rx_data, 0);

      // R12: transmit helper, 0x41 and extremes
      tx_check(3'b001, 8'h41, 1'b1, 1'b1, "R12 R3");
      tx_check(3'b000, 8'h41, 1'b0, 1'b1, "R12 R2");
      tx_check(3'b011, 8'h41, 1'b1, 1'b1, "R12 R4");
      tx_check(3'b010, 8'h41, 1'b0, 1'b1, "R12 R5");
      tx_check(3'b100, 8'h41, 1'b0, 1'b0, "R12 R6");
      tx_check(3'b000, 8'h07, 1'b1, 1'b1, "R12 R2");
      tx_check(3'b001, 8'hFF, 1'b1, 1'b1, "R12 R3");
      tx_check(3'b110, 8'h07, 1'b0, 1'b0, "R12 R6");

      // R1 R2: even mode, good then bad then good (sticky R7)
      par_mode = 3'b000;
      send_frame(8'h41, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b0, "R2", "good even frame", par_err, 0);
      send_frame(8'hA7, 1'b1, 1'b1, 1'b0); do_read();
      check(par_err == 1'b1, "R2", "bad even frame", par_err, 1);
      send_frame(8'h3C, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b1, "R7", "sticky after good frame", par_err, 1);
      do_clear();

      // R3: odd
      par_mode = 3'b001;
      send_frame(8'h41, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b0, "R3", "good odd frame", par_err, 0);
      send_frame(8'h55, 1'b1, 1'b1, 1'b0); do_read();
      check(par_err == 1'b1, "R3", "bad odd frame", par_err, 1);
      do_clear();

      // R4: mark
      par_mode = 3'b011;
      send_frame(8'h80, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b0, "R4", "mark bit 1", par_err, 0);
      send_frame(8'h81, 1'b1, 1'b1, 1'b0); do_read();
      check(par_err == 1'b1, "R4", "mark bit 0", par_err, 1);
      do_clear();

      // R5: space
      par_mode = 3'b010;
      send_frame(8'hFE, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b0, "R5", "space bit 0", par_err, 0);
      send_frame(8'h01, 1'b1, 1'b1, 1'b0); do_read();
      check(par_err == 1'b1, "R5", "space bit 1", par_err, 1);
      do_clear();

      // R6: no parity, including an unused code
      par_mode = 3'b100;
      send_frame(8'h96, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b0, "R6", "no-parity frame", par_err, 0);
      par_mode = 3'b111;
      send_frame(8'h5A, 1'b0, 1'b1, 1'b0); do_read();
      check(par_err == 1'b0, "R6", "unused code frame", par_err, 0);

      // R10: overrun
      par_mode = 3'b000;
      send_frame(8'h11, 1'b0, 1'b1, 1'b0);
      send_frame(8'h22, 1'b0, 1'b0, 1'b0);
      check(rx_data == 8'h22, "R10", "overwritten data", rx_data, 8'h22);
      check(overrun == 1'b1, "R10", "overrun set", overrun, 1);
      check(rx_ready == 1'b1, "R10", "still ready", rx_ready, 1);
      do_clear();
      do_read();

      // R8: clear strobe held across the commit of a bad frame
      send_frame(8'h33, 1'b1, 1'b1, 1'b0); do_read();
      check(par_err == 1'b1, "R8", "error before overlap", par_err, 1);
      send_frame(8'h6B, 1'b1, 1'b1, 1'b1);
      check(par_err == 1'b1, "R8", "new error wins", par_err, 1);
      do_read();
      do_clear();

      // R11: short start pulse is rejected
      rxd = 1'b0;
      repeat (2*TDIV) @(negedge clk);
      rxd = 1'b1;
      repeat (3*BITCLK) @(negedge clk);
      check(rx_ready == 1'b0, "R11", "glitch rejected", rx_ready, 0);
      check(rx_data == 8'h6B, "R11", "data kept", rx_data, 8'h6B);
      send_frame(8'hC4, 1'b0, 1'b1, 1'b0); do_read();
      check(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule